// File: doc/BRIEF.md
# Compare-Match Timer Channel with Slow Reference Clock

This block is one channel of a compare-match timer. A 32-bit counter advances from a slow reference clock through a selectable divider and is compared against a 32-bit compare register. A match raises a flag. Optionally the counter is cleared so that the channel runs periodically. Each match can also be forwarded as a DMA request pulse or as an interrupt level. When the counter rolls over from all ones without a match, an overflow flag is raised.

The slow reference clock reaches the block as a one-cycle strobe, `ref_tick`, in the bus clock domain. Each strobe marks one slow-clock edge. Software writes to the counter register do not act at once. They are held until the second reference tick after the write, and a busy bit in the control/status register reads 1 while such a write is pending. The channel's three registers sit in a 16-byte block at byte address 0x10 + 0x10 * `CH_IDX`, with a 4-byte stride between registers.

Top module: `cmt_channel`

## Requirements
- R1: After reset, control/status reads 0, the counter reads 0, and the compare register reads 0xFFFFFFFF. The control/status register is at byte base 0x10 + 0x10*CH_IDX, the counter at base+4 and the compare register at base+8. Any other address reads 0, and writes to other addresses change nothing.
- R2: Control/status fields: bit 15 match flag, bit 14 overflow flag, bit 13 busy (read-only), bit 8 periodic mode, bit 7 interrupt enable, bits [5:4] request type, bits [2:0] clock select. All other bits read 0.
- R3: A free-running 7-bit count of reference ticks starts at 0 on reset. Clock select 4, 5, 6 or 7 advances the counter on a tick whose pre-tick count modulo 8, 32, 128 or 1 respectively equals that divisor minus 1. Clock select 0 to 3 halts the counter.
- R4: A counter write is loaded on the second reference tick strictly after the write cycle, and that tick does not also count. Until the load, reads return the old value and bit 13 reads 1. A new counter write while busy restarts the wait with the new value.
- R5: A count step with counter equal to compare sets the match flag. In periodic mode the counter goes to 0; otherwise it goes to counter+1.
- R6: A count step from 0xFFFFFFFF that is not a match wraps the counter to 0 and sets the overflow flag.
- R7: Writing 0 to bit 15 or bit 14 of control/status clears that flag, and writing 1 leaves it unchanged. A set event in the same cycle wins over the clear.
- R8: With request type 1, each match step produces a one-cycle `dma_req` pulse in the cycle after the step. Other request types give no pulse.
- R9: `irq` equals match flag AND interrupt enable AND (request type == 2).
- R10: A compare register write takes effect in the next cycle and is used by the next count step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle strobe per slow reference clock edge |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address for read and write |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr`, combinational |
| dma_req | output | 1 | One-cycle DMA request per match |
| irq | output | 1 | Match interrupt level |

## Verification
Every register is updated at the clock edge where its write or event is presented, and read data for the new state is available combinationally right after that edge. A counter load lands at the edge of the second reference tick after the write. `dma_req` rises at the edge of the match step, together with the flag. `irq` follows the flags with no added delay. The bench advances a reference model once per rising edge with the same inputs, samples every output 1 ns after that edge, and drives the next inputs only at that point. As a result, each result is compared in exactly the cycle it is due.

// File: rtl/cmt_pkg.sv
`timescale 1ns/1ps
package cmt_pkg;
  localparam int PRE_W = 7;
  localparam int CSR_W = 16;

  localparam int B_CMF  = 15;
  localparam int B_OVF  = 14;
  localparam int B_BUSY = 13;
  localparam int B_MODE = 8;
  localparam int B_IE   = 7;

  localparam logic [1:0] REQ_DMA = 2'd1;
  localparam logic [1:0] REQ_IRQ = 2'd2;

  typedef struct packed {
    logic       mode;
    logic       ie;
    logic [1:0] rsel;
    logic [2:0] cks;
  } ctrl_t;

  // prescale mask: divisor minus one for the selected count clock
  function automatic logic [PRE_W-1:0] div_mask(input logic [2:0] cks);
    case (cks)
      3'd4:    div_mask = PRE_W'(7);
      3'd5:    div_mask = PRE_W'(31);
      3'd6:    div_mask = PRE_W'(127);
      default: div_mask = '0;
    endcase
  endfunction

  function automatic logic cks_on(input logic [2:0] cks);
    cks_on = cks[2];
  endfunction

  function automatic logic [CSR_W-1:0] pack_csr(input logic cmf, input logic ovf,
                                                input logic busy, input ctrl_t c);
    logic [CSR_W-1:0] r;
    r         = '0;
    r[B_CMF]  = cmf;
    r[B_OVF]  = ovf;
    r[B_BUSY] = busy;
    r[B_MODE] = c.mode;
    r[B_IE]   = c.ie;
    r[5:4]    = c.rsel;
    r[2:0]    = c.cks;
    return r;
  endfunction
endpackage

// File: rtl/cmt_prescaler.sv
`timescale 1ns/1ps
module cmt_prescaler
  import cmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [2:0] cks,
  output logic       step
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  assign mask = div_mask(cks);
  assign step = tick && cks_on(cks) && ((pre_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pre_q <= '0;
    else if (tick) pre_q <= pre_q + PRE_W'(1);
  end
endmodule

// File: rtl/cmt_wr_xing.sv
`timescale 1ns/1ps
module cmt_wr_xing #(
  parameter int W     = 32,
  parameter int TICKS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic         busy,
  output logic         load,
  output logic [W-1:0] load_val
);
  localparam int SW = $clog2(TICKS + 1);

  logic [SW-1:0] seen_q;
  logic          busy_q;
  logic [W-1:0]  hold_q;

  assign busy     = busy_q;
  assign load_val = hold_q;
  assign load     = busy_q && tick && !wr && (seen_q == SW'(TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= '0;
      busy_q <= 1'b0;
      hold_q <= '0;
    end else if (wr) begin
      hold_q <= wdata;
      busy_q <= 1'b1;
      seen_q <= '0;
    end else if (load) begin
      busy_q <= 1'b0;
      seen_q <= '0;
    end else if (busy_q && tick) begin
      seen_q <= seen_q + SW'(1);
    end
  end
endmodule

// File: rtl/cmt_counter.sv
`timescale 1ns/1ps
module cmt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] cor,
  input  logic             periodic,
  output logic [CNT_W-1:0] cnt,
  output logic             match_ev,
  output logic             ovf_ev
);
  logic [CNT_W-1:0] cnt_q;
  logic             eq;

  assign cnt      = cnt_q;
  assign eq       = (cnt_q == cor);
  assign match_ev = step && !load && eq;
  assign ovf_ev   = step && !load && !eq && (cnt_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (step) cnt_q <= (match_ev && periodic) ? '0 : cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/cmt_channel.sv
`timescale 1ns/1ps
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int CH_IDX     = 0,
  parameter int ADDR_W     = 8,
  parameter int CNT_W      = 32,
  parameter int SYNC_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_tick,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic              dma_req,
  output logic              irq
);
  localparam int               BASE_I = 16 + 16 * CH_IDX;
  localparam logic [ADDR_W-1:0] A_CSR = ADDR_W'(BASE_I);
  localparam logic [ADDR_W-1:0] A_CNT = ADDR_W'(BASE_I + 4);
  localparam logic [ADDR_W-1:0] A_COR = ADDR_W'(BASE_I + 8);

  ctrl_t            ctrl_q;
  logic             cmf_q, ovf_q, dma_q;
  logic [CNT_W-1:0] cor_q;
  logic             csr_wr, cnt_wr, cor_wr;
  logic             step_ev, load_ev, match_ev, ovf_ev, busy;
  logic [CNT_W-1:0] load_val, cnt_q;

  assign csr_wr = bus_we && (bus_addr == A_CSR);
  assign cnt_wr = bus_we && (bus_addr == A_CNT);
  assign cor_wr = bus_we && (bus_addr == A_COR);

  cmt_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .tick(ref_tick), .cks(ctrl_q.cks), .step(step_ev)
  );

  cmt_wr_xing #(.W(CNT_W), .TICKS(SYNC_TICKS)) u_xing (
    .clk(clk), .rst_n(rst_n), .tick(ref_tick), .wr(cnt_wr), .wdata(bus_wdata),
    .busy(busy), .load(load_ev), .load_val(load_val)
  );

  cmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step_ev), .load(load_ev), .load_val(load_val),
    .cor(cor_q), .periodic(ctrl_q.mode), .cnt(cnt_q), .match_ev(match_ev), .ovf_ev(ovf_ev)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmf_q  <= 1'b0;
      ovf_q  <= 1'b0;
      dma_q  <= 1'b0;
      cor_q  <= '1;
    end else begin
      dma_q <= match_ev && (ctrl_q.rsel == REQ_DMA);
      if (match_ev)                        cmf_q <= 1'b1;
      else if (csr_wr && !bus_wdata[B_CMF]) cmf_q <= 1'b0;
      if (ovf_ev)                          ovf_q <= 1'b1;
      else if (csr_wr && !bus_wdata[B_OVF]) ovf_q <= 1'b0;
      if (csr_wr) begin
        ctrl_q.mode <= bus_wdata[B_MODE];
        ctrl_q.ie   <= bus_wdata[B_IE];
        ctrl_q.rsel <= bus_wdata[5:4];
        ctrl_q.cks  <= bus_wdata[2:0];
      end
      if (cor_wr) cor_q <= bus_wdata;
    end
  end

  assign dma_req = dma_q;
  assign irq     = cmf_q && ctrl_q.ie && (ctrl_q.rsel == REQ_IRQ);

  always_comb begin
    case (bus_addr)
      A_CSR:   bus_rdata = CNT_W'(pack_csr(cmf_q, ovf_q, busy, ctrl_q));
      A_CNT:   bus_rdata = cnt_q;
      A_COR:   bus_rdata = cor_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cmt_channel_chk.sv
`timescale 1ns/1ps
module cmt_channel_chk
  import cmt_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ref_tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] load_val,
  input logic             busy,
  input logic             load_ev,
  input logic             match_ev,
  input logic             cmf,
  input logic             ovf,
  input ctrl_t            ctrl,
  input logic             dma_req,
  input logic             irq
);
  AST_LOAD_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(ref_tick)); // R4
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    load_ev |=> cnt == $past(load_val)); // R4
  AST_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.cks[2] && !load_ev) |=> $stable(cnt)); // R3
  AST_PERIODIC_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (match_ev && ctrl.mode) |=> cnt == '0); // R5
  AST_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (match_ev && !ctrl.mode) |=> cnt == $past(cnt) + CNT_W'(1)); // R5
  AST_MATCH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    match_ev |=> cmf); // R5
  AST_OVF_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(cnt) == '1); // R6
  AST_DMA_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> ($past(match_ev) && $past(ctrl.rsel) == REQ_DMA)); // R8
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cmf) && ctrl.ie && ctrl.rsel == REQ_IRQ) |-> irq); // R9
endmodule

bind cmt_channel cmt_channel_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .cnt(cnt_q), .load_val(load_val),
  .busy(busy), .load_ev(load_ev), .match_ev(match_ev), .cmf(cmf_q), .ovf(ovf_q),
  .ctrl(ctrl_q), .dma_req(dma_req), .irq(irq)
);

// File: tb/tb_cmt_channel.sv
`timescale 1ns/1ps
module tb_cmt_channel;
  localparam logic [7:0] A_CSR = 8'h10;
  localparam logic [7:0] A_CNT = 8'h14;
  localparam logic [7:0] A_COR = 8'h18;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_tick = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dma_req, irq;

  int checks = 0;
  int failures = 0;
  string cur_tag = "R1";

  // reference model state
  logic [31:0] m_cnt = '0, m_cor = 32'hFFFF_FFFF, m_pend = '0;
  logic        m_cmf = 0, m_ovf = 0, m_mode = 0, m_ie = 0, m_busy = 0, m_dma = 0;
  logic [1:0]  m_rsel = '0;
  logic [2:0]  m_cks = '0;
  int          m_seen = 0, m_pre = 0;

  always #2 clk = ~clk;

  cmt_channel dut (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dma_req(dma_req), .irq(irq)
  );

  function automatic int b_div(input logic [2:0] c);
    case (c)
      3'd4: return 8;
      3'd5: return 32;
      3'd6: return 128;
      3'd7: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] m_read(input logic [7:0] a);
    logic [31:0] v;
    v = '0;
    if (a == A_CSR) begin
      v = {16'd0, m_cmf, m_ovf, m_busy, 4'd0, m_mode, m_ie, 1'b0, m_rsel, 1'b0, m_cks};
    end else if (a == A_CNT) v = m_cnt;
    else if (a == A_COR)     v = m_cor;
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_update(input logic we, input logic [7:0] a, input logic [31:0] d,
                              input logic t);
    logic cw, nw, ow, stp, ld, mt, ov;
    int dv;
    cw  = we && a == A_CSR;
    nw  = we && a == A_CNT;
    ow  = we && a == A_COR;
    dv  = b_div(m_cks);
    stp = t && dv != 0 && ((m_pre % dv) == dv - 1);
    ld  = t && m_busy && !nw && m_seen == 1;
    mt  = stp && !ld && m_cnt == m_cor;
    ov  = stp && !ld && !mt && m_cnt == 32'hFFFF_FFFF;
    m_dma = mt && m_rsel == 2'd1;
    if (ld) m_cnt = m_pend;
    else if (stp) m_cnt = (mt && m_mode) ? 32'd0 : m_cnt + 32'd1;
    if (mt) m_cmf = 1'b1; else if (cw && !d[15]) m_cmf = 1'b0;
    if (ov) m_ovf = 1'b1; else if (cw && !d[14]) m_ovf = 1'b0;
    if (cw) begin
      m_mode = d[8]; m_ie = d[7]; m_rsel = d[5:4]; m_cks = d[2:0];
    end
    if (ow) m_cor = d;
    if (nw) begin m_pend = d; m_busy = 1'b1; m_seen = 0; end
    else if (ld) begin m_busy = 1'b0; m_seen = 0; end
    else if (m_busy && t) m_seen++;
    if (t) m_pre = (m_pre + 1) % 128;
  endtask

  task automatic compare();
    string rt;
    rt = (bus_addr == A_CSR) ? "R2" : (bus_addr == A_COR) ? "R10" : cur_tag;
    chk($sformatf("%s read @%h", rt, bus_addr), bus_rdata, m_read(bus_addr));
    chk("R8 dma_req", 32'(dma_req), 32'(m_dma));
    chk("R9 irq", 32'(irq), 32'(m_cmf && m_ie && m_rsel == 2'd2));
  endtask

  task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d,
                      input logic t);
    bus_we = we; bus_addr = a; bus_wdata = d; ref_tick = t;
    @(posedge clk);
    model_update(we, a, d, t);
    #1;
    compare();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic t);
    step(1'b1, a, d, t);
  endtask

  task automatic rd(input logic [7:0] a, input logic t);
    step(1'b0, a, 32'd0, t);
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    bus_addr = A_COR;
    #1;
    chk("R1 reset compare", bus_rdata, 32'hFFFF_FFFF);
    bus_addr = A_CSR; #0.5;
    chk("R1 reset csr", bus_rdata, 32'd0);
    bus_addr = A_CNT; #0.5;
    chk("R1 reset cnt", bus_rdata, 32'd0);

    // R1: decode and unmapped accesses
    cur_tag = "R1";
    rd(8'h00, 1'b0);
    wr(8'h24, 32'h1234, 1'b0);
    wr(8'h28, 32'h55, 1'b0);
    wr(8'h1C, 32'h0107, 1'b0);
    rd(A_CNT, 1'b1); rd(A_COR, 1'b1); rd(A_CSR, 1'b0); rd(8'h1C, 1'b0);

    // R5: periodic match at compare 3
    cur_tag = "R5";
    wr(A_COR, 32'd3, 1'b0);
    wr(A_CSR, 32'h0107, 1'b0);
    repeat (12) rd(A_CNT, 1'b1);
    wr(A_CSR, 32'h0117, 1'b1);            // DMA routing (R8)
    repeat (10) rd(A_CNT, 1'b1);
    wr(A_CSR, 32'h01A7, 1'b1);            // interrupt routing (R9)
    repeat (6) rd(A_CSR, 1'b1);
    wr(A_CSR, 32'h0027, 1'b0);            // free-running past compare
    repeat (8) rd(A_CNT, 1'b1);

    // R6: overflow without match
    cur_tag = "R6";
    wr(A_CSR, 32'h0007, 1'b0);
    wr(A_COR, 32'd5, 1'b0);
    wr(A_CNT, 32'hFFFF_FFFD, 1'b1);
    repeat (8) rd(A_CNT, 1'b1);
    rd(A_CSR, 1'b0);
    chk("R6 ovf bit", 32'(bus_rdata[14]), 32'd1);

    // R7: write-zero clears
    cur_tag = "R7";
    wr(A_CSR, 32'h8007, 1'b0);
    rd(A_CSR, 1'b0);
    chk("R7 ovf cleared", 32'(bus_rdata[14]), 32'd0);
    wr(A_CSR, 32'h4000, 1'b0);
    rd(A_CSR, 1'b0);

    // R4: delayed counter load
    cur_tag = "R4";
    wr(A_CSR, 32'h0007, 1'b0);
    wr(A_CNT, 32'h100, 1'b0);
    repeat (3) rd(A_CSR, 1'b0);
    chk("R4 busy while pending", 32'(bus_rdata[13]), 32'd1);
    rd(A_CNT, 1'b1); rd(A_CNT, 1'b0);
    chk("R4 old value before load", bus_rdata, m_cnt);
    rd(A_CNT, 1'b1); rd(A_CNT, 1'b0);
    chk("R4 loaded value", bus_rdata, 32'h100);
    wr(A_CNT, 32'h200, 1'b1); rd(A_CNT, 1'b1); wr(A_CNT, 32'h300, 1'b1);
    repeat (4) rd(A_CNT, 1'b1);

    // R3: divider selects and halt
    cur_tag = "R3";
    wr(A_CSR, 32'h0004, 1'b0);
    repeat (40) rd(A_CNT, 1'b1);
    wr(A_CSR, 32'h0002, 1'b1);
    repeat (20) rd(A_CNT, 1'b1);
    wr(A_CSR, 32'h0005, 1'b0);
    repeat (140) rd(A_CNT, 1'b1);
    wr(A_CSR, 32'h0006, 1'b0);
    repeat (300) rd(A_CNT, 1'b1);

    // random mix
    cur_tag = "R4";
    for (int i = 0; i < 4000; i++) begin
      int r;
      logic t;
      logic [7:0] a;
      r = int'($urandom % 100);
      t = ($urandom % 3) != 0;
      if (r < 4) begin
        logic [31:0] d;
        d = $urandom;
        d[2] = ($urandom % 8) != 0;
        d[1:0] = ($urandom % 2) ? 2'b11 : d[1:0];
        wr(A_CSR, d, t);
      end else if (r < 9) begin
        wr(A_CNT, ($urandom % 10 == 0) ? 32'hFFFF_FFF0 + ($urandom % 16) : $urandom % 20, t);
      end else if (r < 11) begin
        wr(A_COR, $urandom % 16, t);
      end else if (r < 12) begin
        wr(8'h30 + 8'($urandom % 16), $urandom, t);
      end else begin
        case ($urandom % 4)
          0: a = A_CSR;
          1: a = A_CNT;
          2: a = A_COR;
          default: a = 8'h0C;
        endcase
        rd(a, t);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule